// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block drives the single chip-select line of a SPI master. A control word holds four fields: a mode bit, a state bit, a two-bit line index and a polarity bit. In software mode, firmware sets the line itself by rewriting the state bit with a read-modify-write of that word. In hardware mode, a small framing sequencer raises chip select around each burst that the serial shifter moves. The sequencer paces itself on a one-cycle strobe that marks each serial clock period. It also tells the shifter when it may start shifting.

A parameter `VER` picks how the polarity and state bits are read. Under `VER = 1`, polarity is the asserted level of the line and state is the raw level to drive. Under `VER = 2`, polarity is the idle level of the line and state is a logical request: 1 asserts and 0 releases. Only line index 0 exists. Any other index keeps the line idle and holds the shifter off. The output comes from a flop, so rewrites of the fields that keep the level the same cannot make it glitch.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset, `ctl_rdata_o` reads software mode with the line released, and `cs_o` sits at the idle level of the reset polarity. With the default `RST_ACT_HIGH = 0`, this is 0x1001 for VER 2, 0x0003 for VER 1 and `cs_o = 1`.
- R2: A write stores bit 0 (mode: 1 software, 0 hardware), bit 1 (state), bits 9:8 (line index) and bit 12 (polarity). All other bits of `ctl_rdata_o` read 0, whatever was written to them.
- R3: With VER 1, software mode and index 0, `cs_o` equals the state bit.
- R4: With VER 2, software mode and index 0, `cs_o` is the inverse of the polarity bit when state is 1, and equals the polarity bit when state is 0.
- R5: `cs_o` takes its new value two clock edges after the edge that samples `ctl_wr_i`. After the first of those edges it still shows the old value.
- R6: While the index field is nonzero, `cs_o` is held at the idle level (VER 1: inverse of polarity; VER 2: polarity) and `shift_go_o` is 0, in either mode.
- R7: In hardware mode, a `sck_tick_i` seen while `tx_pending_i` is high and the sequencer is idle starts a frame. `cs_o` turns active one clock later. `shift_go_o` stays 0 until one more tick has passed, which gives one serial period of lead.
- R8: When a tick arrives with `tx_pending_i` low during shifting, `shift_go_o` drops and chip select stays active for one more tick period. It then goes idle for at least one full tick period before a new frame can start.
- R9: In software mode, `shift_go_o` is 1 and `tx_pending_i` and `sck_tick_i` have no effect on `cs_o`.
- R10: `cs_o` changes only as the result of a register write or a sequencer step. Rewriting the fields to values that give the same level leaves `cs_o` steady on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | DW | Control word write data |
| ctl_rdata_o | output | DW | Control word readback |
| tx_pending_i | input | 1 | Shifter has bytes queued or in flight |
| sck_tick_i | input | 1 | One-cycle strobe per serial clock period |
| shift_go_o | output | 1 | Shifter may shift |
| cs_o | output | 1 | Chip-select line |

## Verification
Several properties are checked on every cycle: chip select never moves without a write or a sequencer step two cycles earlier; a nonzero index always yields the idle level; the sequencer's lead, trail and gap steps follow the pending and tick inputs; and stored words are masked to the defined fields. Other behaviour can only be shown by the bench's scenarios. Those cover the level each version gives for every combination of polarity, state and index, the exact two-edge write latency, the steady output when a field pair is swapped for an equivalent one, and the full frame sequence measured in ticks.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int MODE_BIT  = 0;
  localparam int STATE_BIT = 1;
  localparam int IDX_LO    = 8;
  localparam int IDX_W     = 2;
  localparam int POL_BIT   = 12;
  localparam int FIELD_W   = 13;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_LEAD,
    FR_RUN,
    FR_TRAIL,
    FR_GAP
  } frame_st_e;

  typedef struct packed {
    logic             sw_mode;
    logic             state;
    logic [IDX_W-1:0] idx;
    logic             pol;
  } cs_fields_t;

  function automatic cs_fields_t unpack_ctl(input logic [FIELD_W-1:0] w);
    cs_fields_t f;
    f.sw_mode = w[MODE_BIT];
    f.state   = w[STATE_BIT];
    f.idx     = w[IDX_LO +: IDX_W];
    f.pol     = w[POL_BIT];
    return f;
  endfunction
endpackage

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import spi_cs_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] RST_WORD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  localparam logic [DW-1:0] FIELD_MASK =
      (DW'(1) << MODE_BIT) | (DW'(1) << STATE_BIT) |
      (DW'((1 << IDX_W) - 1) << IDX_LO) | (DW'(1) << POL_BIT);

  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_WORD & FIELD_MASK;
    else if (wr_i) q <= wdata_i & FIELD_MASK;
  end

  assign q_o = q;

  a_r2_field_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o == ($past(wdata_i) & FIELD_MASK)));
endmodule

// File: rtl/cs_frame_fsm.sv
module cs_frame_fsm
  import spi_cs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_en_i,
  input  logic tx_pending_i,
  input  logic tick_i,
  output logic active_o,
  output logic run_o,
  output logic moved_o
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!hw_en_i) st_d = FR_IDLE;
    else if (tick_i) begin
      unique case (st_q)
        FR_IDLE:  if (tx_pending_i) st_d = FR_LEAD;
        FR_LEAD:  st_d = FR_RUN;
        FR_RUN:   if (!tx_pending_i) st_d = FR_TRAIL;
        FR_TRAIL: st_d = FR_GAP;
        FR_GAP:   st_d = FR_IDLE;
        default:  st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FR_IDLE;
    else         st_q <= st_d;
  end

  assign active_o = (st_q == FR_LEAD) || (st_q == FR_RUN) || (st_q == FR_TRAIL);
  assign run_o    = (st_q == FR_RUN);
  assign moved_o  = (st_d != st_q);

  a_r7_lead_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_IDLE && hw_en_i && tx_pending_i && tick_i) |=> (st_q == FR_LEAD));
  a_r8_trail_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_RUN && hw_en_i && !tx_pending_i && tick_i) |=> (st_q == FR_TRAIL));
  a_r8_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_TRAIL && hw_en_i && tick_i) |=> (st_q == FR_GAP && !active_o));
endmodule

// File: rtl/cs_level_decode.sv
module cs_level_decode
  import spi_cs_pkg::*;
#(
  parameter int VER = 2
) (
  input  cs_fields_t f_i,
  input  logic       hw_active_i,
  output logic       lvl_o,
  output logic       idle_lvl_o,
  output logic       idx_ok_o
);
  logic act_lvl, sw_lvl;

  generate
    if (VER == 1) begin : g_raw
      assign act_lvl = f_i.pol;
      assign sw_lvl  = f_i.state;
    end else begin : g_logical
      assign act_lvl = ~f_i.pol;
      assign sw_lvl  = f_i.state ? ~f_i.pol : f_i.pol;
    end
  endgenerate

  assign idx_ok_o   = (f_i.idx == '0);
  assign idle_lvl_o = ~act_lvl;

  always_comb begin
    if (!idx_ok_o)         lvl_o = ~act_lvl;
    else if (f_i.sw_mode)  lvl_o = sw_lvl;
    else                   lvl_o = hw_active_i ? act_lvl : ~act_lvl;
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int VER          = 2,
  parameter bit RST_ACT_HIGH = 1'b0,
  parameter int DW           = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [DW-1:0] ctl_wdata_i,
  output logic [DW-1:0] ctl_rdata_o,
  input  logic          tx_pending_i,
  input  logic          sck_tick_i,
  output logic          shift_go_o,
  output logic          cs_o
);
  localparam bit RST_POL   = (VER == 1) ? RST_ACT_HIGH : ~RST_ACT_HIGH;
  localparam bit RST_STATE = (VER == 1) ? ~RST_ACT_HIGH : 1'b0;
  localparam bit RST_CS    = ~RST_ACT_HIGH;
  localparam logic [DW-1:0] RST_WORD =
      (DW'(1) << MODE_BIT) | (DW'(RST_STATE) << STATE_BIT) | (DW'(RST_POL) << POL_BIT);

  logic [DW-1:0] ctl_q;
  cs_fields_t    fld;
  logic          hw_active, hw_run, fsm_moved;
  logic          lvl, idle_lvl, idx_ok;
  logic          cs_q;

  cs_ctrl_reg #(.DW(DW), .RST_WORD(RST_WORD)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .q_o     (ctl_q)
  );

  assign fld = unpack_ctl(ctl_q[FIELD_W-1:0]);

  cs_frame_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hw_en_i      (~fld.sw_mode & idx_ok),
    .tx_pending_i (tx_pending_i),
    .tick_i       (sck_tick_i),
    .active_o     (hw_active),
    .run_o        (hw_run),
    .moved_o      (fsm_moved)
  );

  cs_level_decode #(.VER(VER)) u_dec (
    .f_i         (fld),
    .hw_active_i (hw_active),
    .lvl_o       (lvl),
    .idle_lvl_o  (idle_lvl),
    .idx_ok_o    (idx_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= RST_CS;
    else         cs_q <= lvl;
  end

  assign cs_o        = cs_q;
  assign ctl_rdata_o = ctl_q;
  assign shift_go_o  = idx_ok & (fld.sw_mode | hw_run);

  a_r6_bad_index_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!idx_ok) |-> (cs_o == $past(idle_lvl)));
  a_r10_no_stray_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(cs_o) |-> ($past(ctl_wr_i, 2) || $past(fsm_moved, 2)));
endmodule

// File: tb/spi_cs_ctrl_test.sv
module spi_cs_ctrl_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          pend = 1'b0;
  logic          tick = 1'b0;
  logic [DW-1:0] rd2, rd1;
  logic          go2, go1, cs2, cs1;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  spi_cs_ctrl #(.VER(2), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rd2), .tx_pending_i(pend), .sck_tick_i(tick),
    .shift_go_o(go2), .cs_o(cs2));

  spi_cs_ctrl #(.VER(1), .DW(DW)) uut_v1 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rd1), .tx_pending_i(pend), .sck_tick_i(tick),
    .shift_go_o(go1), .cs_o(cs1));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit sw, input bit st, input bit [1:0] idx, input bit pol);
    return DW'(sw) | (DW'(st) << 1) | (DW'(idx) << 8) | (DW'(pol) << 12);
  endfunction

  // expected line level for software mode
  function automatic logic lvl_exp(input int ver, input bit st, input bit [1:0] idx, input bit pol);
    logic act;
    act = (ver == 1) ? pol : ~pol;
    if (idx != 0) return ~act;
    if (ver == 1) return st;
    return st ? ~pol : pol;
  endfunction

  task automatic write_word(input logic [DW-1:0] w);
    @(negedge clk); wr = 1'b1; wdata = w;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_both(input string req, input logic e2, input logic e1, input logic g);
    chk(req, DW'(cs2), DW'(e2));
    chk(req, DW'(cs1), DW'(e1));
    chk(req, DW'(go2), DW'(g));
    chk(req, DW'(go1), DW'(g));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic p2, p1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rd2, 16'h1001);
    chk("R1", rd1, 16'h0003);
    chk("R1", DW'(cs2), DW'(1));
    chk("R1", DW'(cs1), DW'(1));
    p2 = cs2; p1 = cs1;

    // R2..R6, R9: sweep of every software-mode field combination
    for (int k = 0; k < 32; k++) begin
      bit st, pol, junk;
      bit [1:0] idx;
      logic [DW-1:0] w;
      st = k[0]; pol = k[1]; idx = k[3:2]; junk = k[4];
      w = mk(1'b1, st, idx, pol) | (junk ? 16'hE4FC : 16'h0000);
      write_word(w);
      chk("R5", DW'(cs2), DW'(p2));
      chk("R5", DW'(cs1), DW'(p1));
      @(negedge clk);
      chk("R2", rd2, mk(1'b1, st, idx, pol));
      chk("R2", rd1, mk(1'b1, st, idx, pol));
      chk("R4", DW'(cs2), DW'(lvl_exp(2, st, idx, pol)));
      chk("R3", DW'(cs1), DW'(lvl_exp(1, st, idx, pol)));
      chk(idx != 0 ? "R6" : "R9", DW'(go2), DW'(idx == 0));
      chk(idx != 0 ? "R6" : "R9", DW'(go1), DW'(idx == 0));
      p2 = cs2; p1 = cs1;
    end

    // R9: shifter inputs ignored in software mode
    write_word(mk(1'b1, 1'b1, 2'd0, 1'b0));
    @(negedge clk);
    pend = 1'b1;
    for (int t = 0; t < 4; t++) do_tick();
    chk("R9", DW'(cs2), DW'(1));
    chk("R9", DW'(cs1), DW'(1));
    chk("R9", DW'(go2), DW'(1));
    pend = 1'b0;
    do_tick();
    chk("R9", DW'(cs2), DW'(1));

    // R10: equivalent rewrites keep the line steady every cycle
    write_word(mk(1'b1, 1'b1, 2'd0, 1'b0));
    @(negedge clk);
    write_word(mk(1'b1, 1'b1, 2'd0, 1'b1));
    for (int c = 0; c < 3; c++) begin
      chk("R10", DW'(cs1), DW'(1));
      @(negedge clk);
    end
    write_word(mk(1'b1, 1'b0, 2'd0, 1'b1));
    @(negedge clk);
    chk("R10", DW'(cs2), DW'(1));
    write_word(mk(1'b1, 1'b1, 2'd0, 1'b0));
    for (int c = 0; c < 3; c++) begin
      chk("R10", DW'(cs2), DW'(1));
      @(negedge clk);
    end

    // hardware mode, polarity bit 1: VER1 active 1, VER2 active 0
    write_word(mk(1'b0, 1'b0, 2'd0, 1'b1));
    @(negedge clk);
    chk_both("R7", 1'b1, 1'b0, 1'b0);
    do_tick();
    chk_both("R7", 1'b1, 1'b0, 1'b0);
    pend = 1'b1;
    do_tick();
    chk_both("R7", 1'b0, 1'b1, 1'b0);
    do_tick();
    chk_both("R7", 1'b0, 1'b1, 1'b1);
    do_tick();
    chk_both("R7", 1'b0, 1'b1, 1'b1);
    pend = 1'b0;
    do_tick();
    chk_both("R8", 1'b0, 1'b1, 1'b0);
    pend = 1'b1;
    do_tick();
    chk_both("R8", 1'b1, 1'b0, 1'b0);
    do_tick();
    chk_both("R8", 1'b1, 1'b0, 1'b0);
    do_tick();
    chk_both("R8", 1'b0, 1'b1, 1'b0);

    // R6: nonzero index in hardware mode forces idle
    write_word(mk(1'b0, 1'b0, 2'd2, 1'b1));
    @(negedge clk);
    chk_both("R6", 1'b1, 1'b0, 1'b0);
    do_tick();
    do_tick();
    chk_both("R6", 1'b1, 1'b0, 1'b0);
    pend = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule